// File: doc/BRIEF.md
# USB OUT Endpoint Receive Buffer

This block holds the received data for one USB OUT endpoint. The USB engine streams the bytes of each packet into it and marks the final byte. The buffer stores each packet and records its length. Firmware then sees a packet-ready flag and a byte-count value, and takes the bytes from a read stream.

Each packet is committed only after its last byte arrives. A packet that does not fit in the free space is rejected whole, and the bytes already held stay intact. The read side shows one packet at a time. The packet-ready flag drops when firmware unloads the head packet. Unloading happens in one of two ways, chosen by a mode input: firmware can clear the packet, or the buffer unloads it by itself once a programmed maximum-packet-size number of bytes has been read. While further packets are queued, unloading the head packet does not drop the flag. The byte count then shows the next packet's length.

Back-pressure rules: an input beat is taken on any cycle where `in_valid` and `in_ready` are both high. `in_ready` is low only while the length queue already holds `MAX_PKTS` packets, and a packet in progress simply stalls until it rises again. A byte leaves on any cycle where `out_valid` and `out_ready` are both high. `out_ready` has no effect while `out_valid` is low.

Top module: `usb_out_ep_buf`

## Requirements
- R1: After reset `pkt_rdy`=0, `out_valid`=0, `out_data`=0, `byte_cnt`=0 and `in_ready`=1.
- R2: On the clock edge that takes a beat with `in_last`=1 for a packet that fits, the packet is committed. From the next cycle `pkt_rdy`=1 and `byte_cnt` equals the packet's length. `byte_cnt` is 0 whenever no packet is held.
- R3: The bytes of the head packet leave in arrival order, one per handshake. `out_valid` is 1 only while the head packet still has unread bytes, so a read never crosses into the next packet.
- R4: While `out_valid`=0, `out_data` is 0, and asserting `out_ready` moves no pointer: the next bytes read are still the correct ones.
- R5: With `auto_clr`=1, the read that brings the bytes taken from the head packet to `max_pkt` unloads that packet on the same edge. A packet shorter than `max_pkt` is not unloaded automatically.
- R6: With `auto_clr`=0, `pkt_rdy` stays 1 after all bytes are read, and stays 1 until `sw_clr` is pulsed.
- R7: A `sw_clr` pulse unloads the head packet and drops any of its unread bytes. If another packet is queued, `pkt_rdy` stays 1 and `byte_cnt` shows the next packet's length.
- R8: A packet whose bytes exceed the free space is rejected whole. No packet is queued, held bytes are unchanged, and no space is used up.
- R9: `in_ready` is 0 while `MAX_PKTS` packets are queued, and returns to 1 once one of them is unloaded.
- R10: `sw_clr` while no packet is held has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Received byte present |
| in_ready | output | 1 | Buffer can take a byte |
| in_data | input | DATA_W | Received byte |
| in_last | input | 1 | Beat carries the final byte of a packet |
| out_valid | output | 1 | Head packet has an unread byte |
| out_ready | input | 1 | Firmware takes the byte |
| out_data | output | DATA_W | Byte at the read position, 0 when none |
| pkt_rdy | output | 1 | At least one packet held |
| byte_cnt | output | CNT_W | Length of the head packet |
| auto_clr | input | 1 | 1: unload after max_pkt bytes are read |
| max_pkt | input | CNT_W | Maximum packet size in bytes |
| sw_clr | input | 1 | One-cycle pulse that unloads the head packet |

## Verification
A fill counter or read pointer that is off by even one byte shows up at once as a wrong `out_data` value on the next read. It also shows up later as a length mismatch: an exactly full packet is refused, or a packet that should overflow is accepted. A wrong length-queue entry is visible in `byte_cnt` on the cycle after a commit or an unload. A wrong unload rule shows in `pkt_rdy` on the cycle right after the deciding read or pulse. The sweeps cover every packet length and every `max_pkt` value of a 16-byte buffer, with the read pointer wrapping at many different offsets.

// File: rtl/uoe_pkg.sv
package uoe_pkg;
  // Modular advance of a ring pointer; step never exceeds depth.
  function automatic int unsigned ring_add(int unsigned base, int unsigned step,
                                           int unsigned depth);
    int unsigned s;
    s = base + step;
    if (s >= depth) s = s - depth;
    return s;
  endfunction
endpackage

// File: rtl/uoe_byte_store.sv
module uoe_byte_store #(
  parameter int DEPTH  = 32,
  parameter int DATA_W = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PTR_W-1:0]  waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [PTR_W-1:0]  raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/uoe_len_queue.sv
module uoe_len_queue #(
  parameter int ENTRIES = 4,
  parameter int LEN_W   = 6,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int QC_W   = $clog2(ENTRIES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [LEN_W-1:0] push_len,
  input  logic             pop,
  output logic [LEN_W-1:0] head,
  output logic [QC_W-1:0]  count,
  output logic             full
);
  localparam logic [QC_W-1:0]  FULL_CNT = QC_W'(ENTRIES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

  logic [LEN_W-1:0] q [ENTRIES];
  logic [IDX_W-1:0] rd_i, wr_i;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
    return (i == LAST_IDX) ? '0 : i + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) q[wr_i] <= push_len;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_i  <= '0;
      wr_i  <= '0;
      count <= '0;
    end else begin
      if (push) wr_i <= step(wr_i);
      if (pop)  rd_i <= step(rd_i);
      count <= count + QC_W'(push) - QC_W'(pop);
    end
  end

  assign full = (count == FULL_CNT);
  assign head = (count != '0) ? q[rd_i] : '0;

  // R9: the producer never pushes into a full queue
  a_r9_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (!full || pop));
  // R7: every unload removes exactly one record
  a_r7_pop_count: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/uoe_ingress.sv
module uoe_ingress #(
  parameter int DEPTH  = 32,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             beat,
  input  logic             last,
  input  logic [CNT_W-1:0] fill,
  output logic             we,
  output logic [PTR_W-1:0] waddr,
  output logic             commit,
  output logic [CNT_W-1:0] commit_len
);
  localparam logic [CNT_W:0] DEPTH_X = (CNT_W+1)'(DEPTH);

  logic [PTR_W-1:0] wr_base;
  logic [CNT_W-1:0] stage_cnt;
  logic             stage_bad;
  logic             fits;

  assign fits       = ({1'b0, fill} + {1'b0, stage_cnt}) < DEPTH_X;
  assign we         = beat && fits && !stage_bad;
  assign commit     = we && last;
  assign commit_len = stage_cnt + 1'b1;
  assign waddr      = PTR_W'(uoe_pkg::ring_add(32'(wr_base), 32'(stage_cnt),
                                                 32'(DEPTH)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_base   <= '0;
      stage_cnt <= '0;
      stage_bad <= 1'b0;
    end else if (beat) begin
      if (last) begin
        stage_cnt <= '0;
        stage_bad <= 1'b0;
        if (commit)
          wr_base <= PTR_W'(uoe_pkg::ring_add(32'(wr_base), 32'(commit_len),
                                              32'(DEPTH)));
      end else if (we) begin
        stage_cnt <= stage_cnt + 1'b1;
      end else begin
        stage_bad <= 1'b1;
      end
    end
  end

  // R8: a committed packet always fits what the buffer can hold
  a_r8_commit_size: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (({1'b0, fill} + {1'b0, commit_len}) <= DEPTH_X));
  // R8: a packet that lost a byte is never committed
  a_r8_bad_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    stage_bad |-> !commit);
endmodule

// File: rtl/usb_out_ep_buf.sv
module usb_out_ep_buf #(
  parameter int DEPTH    = 32,
  parameter int DATA_W   = 8,
  parameter int MAX_PKTS = 4,
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int QC_W    = $clog2(MAX_PKTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              pkt_rdy,
  output logic [CNT_W-1:0]  byte_cnt,
  input  logic              auto_clr,
  input  logic [CNT_W-1:0]  max_pkt,
  input  logic              sw_clr
);
  logic [PTR_W-1:0]  rd_ptr, waddr;
  logic [CNT_W-1:0]  fill, took, took_n, head_len, commit_len, consumed;
  logic [QC_W-1:0]   lq_cnt;
  logic [DATA_W-1:0] rdata;
  logic              lq_full, have, beat, we, commit, pop, auto_hit, unload;

  assign beat     = in_valid && in_ready;
  assign in_ready = !lq_full;

  uoe_ingress #(.DEPTH(DEPTH)) u_ingress (
    .clk(clk), .rst_n(rst_n), .beat(beat), .last(in_last), .fill(fill),
    .we(we), .waddr(waddr), .commit(commit), .commit_len(commit_len)
  );

  uoe_byte_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(we), .waddr(waddr), .wdata(in_data),
    .raddr(rd_ptr), .rdata(rdata)
  );

  uoe_len_queue #(.ENTRIES(MAX_PKTS), .LEN_W(CNT_W)) u_lens (
    .clk(clk), .rst_n(rst_n), .push(commit), .push_len(commit_len),
    .pop(unload), .head(head_len), .count(lq_cnt), .full(lq_full)
  );

  // Read side: one packet at a time, unloaded by pulse or by size match.
  assign have      = (lq_cnt != '0);
  assign out_valid = have && (took < head_len);
  assign out_data  = out_valid ? rdata : '0;
  assign pop       = out_valid && out_ready;
  assign took_n    = took + CNT_W'(pop);
  assign auto_hit  = auto_clr && pop && (took_n == max_pkt);
  assign unload    = have && (sw_clr || auto_hit);
  assign consumed  = unload ? (head_len - took) : CNT_W'(pop);
  assign pkt_rdy   = have;
  assign byte_cnt  = head_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      fill   <= '0;
      took   <= '0;
    end else begin
      rd_ptr <= PTR_W'(uoe_pkg::ring_add(32'(rd_ptr), 32'(consumed), 32'(DEPTH)));
      fill   <= fill + (commit ? commit_len : '0) - consumed;
      took   <= unload ? '0 : took_n;
    end
  end

  // R3: bytes are offered only while a packet is held
  a_r3_valid_has_pkt: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> pkt_rdy);
  // R4: no packet held means no byte counted in the buffer
  a_r4_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (lq_cnt == '0) |-> (fill == '0));
  // R8: the fill counter never passes the depth
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= CNT_W'(DEPTH));
  // R5: reads never run past the head packet
  a_r5_took_bound: assert property (@(posedge clk) disable iff (!rst_n)
    have |-> (took <= head_len));
  // R6: in manual mode the flag only falls on a clear pulse
  a_r6_manual_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!auto_clr && !sw_clr && have) |=> pkt_rdy);
endmodule

// File: tb/test_usb_out_ep_buf.sv
module test_usb_out_ep_buf;
  localparam int DEPTH = 16;
  localparam int NPKT  = 3;
  localparam int CW    = $clog2(DEPTH + 1);

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_last = 0, out_ready = 0, auto_clr = 0, sw_clr = 0;
  logic [7:0] in_data = '0;
  logic [CW-1:0] max_pkt = '0;
  logic in_ready, out_valid, pkt_rdy;
  logic [7:0] out_data;
  logic [CW-1:0] byte_cnt;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  usb_out_ep_buf #(.DEPTH(DEPTH), .DATA_W(8), .MAX_PKTS(NPKT)) i_usb_out_ep_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .pkt_rdy(pkt_rdy),
    .byte_cnt(byte_cnt), .auto_clr(auto_clr), .max_pkt(max_pkt), .sw_clr(sw_clr)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic send_pkt(input int len, input int seed);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_data  = 8'(seed + i);
      in_last  = (i == len - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic read_bytes(input int n, input int seed, input string req);
    for (int i = 0; i < n; i++) begin
      chk({req, " valid"}, int'(out_valid), 1);
      chk({req, " data"}, int'(out_data), (seed + i) & 255);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
    end
  endtask

  task automatic pulse_clr();
    sw_clr = 1'b1;
    @(negedge clk);
    sw_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++; nchk++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pkt_rdy", int'(pkt_rdy), 0);
    chk("R1 out_valid", int'(out_valid), 0);
    chk("R1 out_data", int'(out_data), 0);
    chk("R1 byte_cnt", int'(byte_cnt), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 in_ready", int'(in_ready), 1);

    // R10: a clear pulse with nothing held changes nothing
    pulse_clr();
    chk("R10 pkt_rdy", int'(pkt_rdy), 0);
    send_pkt(2, 200);
    chk("R10 byte_cnt", int'(byte_cnt), 2);
    read_bytes(2, 200, "R10");
    pulse_clr();

    // Manual mode sweep over every length (R2, R3, R4, R6)
    for (int len = 1; len <= DEPTH; len++) begin
      send_pkt(len, len * 7);
      chk("R2 pkt_rdy", int'(pkt_rdy), 1);
      chk("R2 byte_cnt", int'(byte_cnt), len);
      read_bytes(len, len * 7, "R3");
      chk("R3 valid after packet", int'(out_valid), 0);
      chk("R4 data when idle", int'(out_data), 0);
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
      chk("R6 flag held", int'(pkt_rdy), 1);
      pulse_clr();
      chk("R6 flag cleared", int'(pkt_rdy), 0);
      chk("R2 byte_cnt empty", int'(byte_cnt), 0);
    end

    // R4: empty reads leave the pointer in place
    out_ready = 1'b1;
    repeat (3) @(negedge clk);
    out_ready = 1'b0;
    send_pkt(5, 90);
    read_bytes(5, 90, "R4 after empty reads");
    pulse_clr();

    // Auto mode sweep over every max_pkt (R5)
    auto_clr = 1'b1;
    for (int m = 1; m <= DEPTH; m++) begin
      max_pkt = CW'(m);
      send_pkt(m, m * 3 + 1);
      read_bytes(m - 1, m * 3 + 1, "R5");
      chk("R5 before last byte", int'(pkt_rdy), 1);
      read_bytes(1, m * 3 + 1 + m - 1, "R5");
      chk("R5 auto unload", int'(pkt_rdy), 0);
      if (m > 1) begin
        send_pkt(m - 1, 50);
        read_bytes(m - 1, 50, "R5 short");
        chk("R5 short packet kept", int'(pkt_rdy), 1);
        pulse_clr();
        chk("R5 short cleared", int'(pkt_rdy), 0);
      end
    end
    max_pkt = CW'(4);
    send_pkt(4, 10);
    send_pkt(3, 20);
    read_bytes(4, 10, "R5 queued");
    chk("R5 next flag", int'(pkt_rdy), 1);
    chk("R5 next count", int'(byte_cnt), 3);
    read_bytes(3, 20, "R5 queued");
    pulse_clr();
    chk("R5 drained", int'(pkt_rdy), 0);
    auto_clr = 1'b0;

    // R7: clear drops unread bytes, next packet shows
    send_pkt(3, 30);
    send_pkt(5, 40);
    send_pkt(2, 60);
    chk("R7 first count", int'(byte_cnt), 3);
    read_bytes(1, 30, "R7");
    pulse_clr();
    chk("R7 flag stays", int'(pkt_rdy), 1);
    chk("R7 second count", int'(byte_cnt), 5);
    read_bytes(5, 40, "R7");
    pulse_clr();
    chk("R7 third count", int'(byte_cnt), 2);
    read_bytes(2, 60, "R7");
    pulse_clr();
    chk("R7 empty", int'(pkt_rdy), 0);

    // R9: length queue full holds off input
    send_pkt(1, 1);
    send_pkt(1, 2);
    send_pkt(1, 3);
    chk("R9 ready low", int'(in_ready), 0);
    pulse_clr();
    chk("R9 ready back", int'(in_ready), 1);
    read_bytes(1, 2, "R9");
    pulse_clr();
    read_bytes(1, 3, "R9");
    pulse_clr();

    // R8: overflowing packet rejected, space untouched
    send_pkt(10, 100);
    send_pkt(10, 150);
    chk("R8 count kept", int'(byte_cnt), 10);
    read_bytes(10, 100, "R8 held data");
    chk("R8 no extra bytes", int'(out_valid), 0);
    pulse_clr();
    chk("R8 no rejected packet", int'(pkt_rdy), 0);
    send_pkt(DEPTH, 170);
    chk("R8 full packet fits", int'(byte_cnt), DEPTH);
    read_bytes(DEPTH, 170, "R8 full");
    pulse_clr();
    send_pkt(10, 5);
    send_pkt(6, 77);
    pulse_clr();
    chk("R8 exact fit count", int'(byte_cnt), 6);
    read_bytes(6, 77, "R8 exact fit");
    pulse_clr();

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule